// File: doc/BRIEF.md
# Bidirectional Bus Transceiver with Parity Generation and Checking

This block joins two byte-wide buses, called the A side and the B side, and moves data between them in one direction at a time. A direction input chooses the flow. With it high the block transmits, copying A onto B. With it low the block receives, copying B onto A. An active-low output enable, when high, turns off every driver the block owns.

Alongside the data path sits a parity unit. The sense input picks the parity convention. In transmit the block computes a parity bit from the A data and drives it onto the parity line. In receive the parity line belongs to the far end: the block reads it, checks it against the B data and the sense input, and reports on an active-low error flag.

Each tri-state pin is modelled as a value output paired with a drive-enable output. The surrounding pad ring or bus resolver combines the two into a real three-state pin. The block is purely combinational.

Top module: `bus_xcvr_par`

## Requirements
- R1: With the enable low and the direction input high (transmit), `b_out_o` equals `a_in_i` bit for bit and `b_drive_o` is 1.
- R2: With the enable low and the direction input low (receive), `a_out_o` equals `b_in_i` bit for bit and `a_drive_o` is 1.
- R3: With `oe_n_i` high, all four drive outputs (`a_drive_o`, `b_drive_o`, `par_drive_o`, `err_drive_o`) are 0. `a_out_o`, `b_out_o` and `par_out_o` read 0, and `err_n_o` reads 1.
- R4: In transmit with the enable low, `par_drive_o` is 1 and `par_out_o` is the XOR of `odd_sel_i` and the XOR of all A bits. So with `odd_sel_i` = 1 and an even count of ones on A, the output is 1.
- R5: In receive with the enable low, `err_n_o` is the inverse of (`odd_sel_i` XOR XOR-of-B XOR `par_in_i`). With `odd_sel_i` = 1 and `par_in_i` = 1, an even count of ones on B gives 1 (no error) and an odd count gives 0 (error). `err_drive_o` is 1.
- R6: In transmit with the enable low, `err_drive_o` is 1 and `err_n_o` is 1, whatever the data.
- R7: The side the block is not driving is released. In transmit `a_drive_o` is 0 and `a_out_o` is 0. In receive `b_drive_o` is 0, `b_out_o` is 0, `par_drive_o` is 0 and `par_out_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dir_tx_i | input | 1 | Direction: 1 = A to B (transmit), 0 = B to A (receive) |
| oe_n_i | input | 1 | Active-low enable for all drivers |
| odd_sel_i | input | 1 | Parity sense select |
| a_in_i | input | 8 | Level seen on the A bus |
| a_out_o | output | 8 | Value driven onto the A bus |
| a_drive_o | output | 1 | Drive enable for the A bus |
| b_in_i | input | 8 | Level seen on the B bus |
| b_out_o | output | 8 | Value driven onto the B bus |
| b_drive_o | output | 1 | Drive enable for the B bus |
| par_in_i | input | 1 | Level seen on the parity line |
| par_out_o | output | 1 | Value driven onto the parity line |
| par_drive_o | output | 1 | Drive enable for the parity line |
| err_n_o | output | 1 | Active-low parity error flag |
| err_drive_o | output | 1 | Drive enable for the error flag |

## Verification
The bench sweeps all 256 byte values under every combination of direction, enable, sense and incoming parity bit. It feeds the idle bus with the complement of the active data, so any leak from the wrong side shows up as a mismatch. The full sweep covers every odd and every even ones count with both sense values, which separates a correct parity rule from an inverted or wrongly selected one. It also covers both incoming parity levels in receive, which tells a true three-way check from one that ignores the received bit. The disabled passes confirm that every driver is off and that values are parked regardless of data.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef enum logic {
    XFER_RX = 1'b0,
    XFER_TX = 1'b1
  } xfer_dir_e;

  typedef struct packed {
    logic a_en;
    logic b_en;
    logic par_en;
    logic err_en;
    logic chk_en;
  } drive_set_t;

endpackage

// File: rtl/xcvr_par_tree.sv
module xcvr_par_tree #(
  parameter int W = 8
) (
  input  logic [W-1:0] data_i,
  input  logic         sense_i,
  output logic         par_o
);

  logic acc;

  always_comb begin
    acc = sense_i;
    for (int i = 0; i < W; i++) begin
      acc = acc ^ data_i[i];
    end
  end

  assign par_o = acc;

endmodule

// File: rtl/xcvr_ctrl.sv
module xcvr_ctrl
  import xcvr_pkg::*;
(
  input  logic       dir_tx_i,
  input  logic       oe_n_i,
  output drive_set_t drv_o
);

  xfer_dir_e dir;
  logic      live;

  assign dir  = xfer_dir_e'(dir_tx_i);
  assign live = ~oe_n_i;

  always_comb begin
    drv_o        = '0;
    drv_o.err_en = live;
    if (live) begin
      unique case (dir)
        XFER_TX: begin
          drv_o.b_en   = 1'b1;
          drv_o.par_en = 1'b1;
        end
        XFER_RX: begin
          drv_o.a_en   = 1'b1;
          drv_o.chk_en = 1'b1;
        end
        default: drv_o = '0;
      endcase
    end
  end

endmodule

// File: rtl/xcvr_path.sv
module xcvr_path #(
  parameter int W = 8
) (
  input  logic [W-1:0] src_i,
  input  logic         en_i,
  output logic [W-1:0] dst_o
);

  for (genvar g = 0; g < W; g++) begin : g_bit
    assign dst_o[g] = src_i[g] & en_i;
  end

endmodule

// File: rtl/bus_xcvr_par.sv
module bus_xcvr_par
  import xcvr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              dir_tx_i,
  input  logic              oe_n_i,
  input  logic              odd_sel_i,
  input  logic [DATA_W-1:0] a_in_i,
  output logic [DATA_W-1:0] a_out_o,
  output logic              a_drive_o,
  input  logic [DATA_W-1:0] b_in_i,
  output logic [DATA_W-1:0] b_out_o,
  output logic              b_drive_o,
  input  logic              par_in_i,
  output logic              par_out_o,
  output logic              par_drive_o,
  output logic              err_n_o,
  output logic              err_drive_o
);

  drive_set_t drv;
  logic       gen_par;
  logic       chk_sum;

  xcvr_ctrl u_ctrl (
    .dir_tx_i (dir_tx_i),
    .oe_n_i   (oe_n_i),
    .drv_o    (drv)
  );

  xcvr_path #(.W(DATA_W)) u_a2b (
    .src_i (a_in_i),
    .en_i  (drv.b_en),
    .dst_o (b_out_o)
  );

  xcvr_path #(.W(DATA_W)) u_b2a (
    .src_i (b_in_i),
    .en_i  (drv.a_en),
    .dst_o (a_out_o)
  );

  xcvr_par_tree #(.W(DATA_W)) u_gen (
    .data_i  (a_in_i),
    .sense_i (odd_sel_i),
    .par_o   (gen_par)
  );

  xcvr_par_tree #(.W(DATA_W + 1)) u_chk (
    .data_i  ({par_in_i, b_in_i}),
    .sense_i (odd_sel_i),
    .par_o   (chk_sum)
  );

  assign a_drive_o   = drv.a_en;
  assign b_drive_o   = drv.b_en;
  assign par_drive_o = drv.par_en;
  assign par_out_o   = gen_par & drv.par_en;
  assign err_drive_o = drv.err_en;
  assign err_n_o     = ~(chk_sum & drv.chk_en);

endmodule

// File: rtl/bus_xcvr_par_chk.sv
module bus_xcvr_par_chk #(
  parameter int DATA_W = 8
) (
  input logic              dir_tx_i,
  input logic              oe_n_i,
  input logic              odd_sel_i,
  input logic [DATA_W-1:0] a_in_i,
  input logic [DATA_W-1:0] a_out_o,
  input logic              a_drive_o,
  input logic [DATA_W-1:0] b_in_i,
  input logic [DATA_W-1:0] b_out_o,
  input logic              b_drive_o,
  input logic              par_in_i,
  input logic              par_out_o,
  input logic              par_drive_o,
  input logic              err_n_o,
  input logic              err_drive_o
);

  logic a_odd, b_odd;
  assign a_odd = $countones(a_in_i) % 2 == 1;
  assign b_odd = $countones(b_in_i) % 2 == 1;

  always_comb begin
    // R1
    tx_copy_chk: assert (!(!oe_n_i && dir_tx_i) || (b_drive_o && b_out_o == a_in_i));
    // R2
    rx_copy_chk: assert (!(!oe_n_i && !dir_tx_i) || (a_drive_o && a_out_o == b_in_i));
    // R3
    all_off_chk: assert (!oe_n_i || ({a_drive_o, b_drive_o, par_drive_o, err_drive_o} == 4'b0000
                                      && a_out_o == '0 && b_out_o == '0 && !par_out_o && err_n_o));
    // R4
    tx_par_chk: assert (!(!oe_n_i && dir_tx_i) || (par_drive_o && par_out_o == (odd_sel_i != a_odd)));
    // R5
    rx_err_chk: assert (!(!oe_n_i && !dir_tx_i) ||
                        (err_drive_o && (err_n_o == ((odd_sel_i != b_odd) == par_in_i))));
    // R6
    tx_noerr_chk: assert (!(!oe_n_i && dir_tx_i) || (err_drive_o && err_n_o));
    // R7
    one_driver_chk: assert (!(a_drive_o && (b_drive_o || par_drive_o)));
  end

endmodule

bind bus_xcvr_par bus_xcvr_par_chk #(.DATA_W(DATA_W)) u_chk_bind (.*);

// File: tb/bus_xcvr_par_tb_top.sv
module bus_xcvr_par_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic         dir_tx, oe_n, odd_sel, par_in;
  logic [W-1:0] a_in, b_in;
  logic [W-1:0] a_out, b_out;
  logic         a_drive, b_drive, par_out, par_drive, err_n, err_drive;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  bus_xcvr_par #(.DATA_W(W)) dut_i (
    .dir_tx_i    (dir_tx),
    .oe_n_i      (oe_n),
    .odd_sel_i   (odd_sel),
    .a_in_i      (a_in),
    .a_out_o     (a_out),
    .a_drive_o   (a_drive),
    .b_in_i      (b_in),
    .b_out_o     (b_out),
    .b_drive_o   (b_drive),
    .par_in_i    (par_in),
    .par_out_o   (par_out),
    .par_drive_o (par_drive),
    .err_n_o     (err_n),
    .err_drive_o (err_drive)
  );

  function automatic bit odd_ones(input logic [W-1:0] v);
    int n = 0;
    for (int i = 0; i < W; i++) if (v[i]) n++;
    return (n % 2) == 1;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (dir=%0d oe_n=%0d sel=%0d pin=%0d a=%0h b=%0h)",
               req, act, exp, dir_tx, oe_n, odd_sel, par_in, a_in, b_in);
    end
  endtask

  task automatic apply(input bit d, input bit o, input bit s, input bit p, input logic [W-1:0] v);
    @(posedge clk);
    #1;
    dir_tx  = d;
    oe_n    = o;
    odd_sel = s;
    par_in  = p;
    if (d) begin a_in = v;  b_in = ~v; end
    else   begin b_in = v;  a_in = ~v; end
    @(negedge clk);
  endtask

  task automatic verify();
    bit exp_par, exp_err;
    if (oe_n) begin
      chk("R3 drives", {a_drive, b_drive, par_drive, err_drive}, 0);
      chk("R3 values", {a_out, b_out, par_out, err_n}, 1);
    end else if (dir_tx) begin
      exp_par = odd_sel ^ odd_ones(a_in);
      chk("R1 b_out", b_out, a_in);
      chk("R1 b_drive", b_drive, 1);
      chk("R4 par_out", par_out, exp_par);
      chk("R4 par_drive", par_drive, 1);
      chk("R6 err", {err_drive, err_n}, 3);
      chk("R7 a released", {a_drive, a_out}, 0);
    end else begin
      exp_err = !(odd_sel ^ odd_ones(b_in) ^ par_in);
      chk("R2 a_out", a_out, b_in);
      chk("R2 a_drive", a_drive, 1);
      chk("R5 err_n", err_n, exp_err);
      chk("R5 err_drive", err_drive, 1);
      chk("R7 b released", {b_drive, b_out}, 0);
      chk("R7 par released", {par_drive, par_out}, 0);
    end
  endtask

  initial begin
    dir_tx = 1'b0; oe_n = 1'b1; odd_sel = 1'b0; par_in = 1'b0;
    a_in = '0; b_in = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R3: idle state after reset with the enable high
    chk("R3 reset drives", {a_drive, b_drive, par_drive, err_drive}, 0);
    chk("R3 reset err_n", err_n, 1);

    // R4 / R5 spot cases named by the requirements
    apply(1, 0, 1, 0, 8'h03);
    chk("R4 sel1 even ones", par_out, 1);
    apply(0, 0, 1, 1, 8'h11);
    chk("R5 sel1 pin1 even ones", err_n, 1);
    apply(0, 0, 1, 1, 8'h07);
    chk("R5 sel1 pin1 odd ones", err_n, 0);
    apply(1, 0, 0, 1, 8'hFF);
    chk("R4 sel0 even ones", par_out, 0);

    for (int d = 0; d < 2; d++)
      for (int o = 0; o < 2; o++)
        for (int s = 0; s < 2; s++)
          for (int p = 0; p < 2; p++)
            for (int v = 0; v < 256; v++) begin
              apply(d[0], o[0], s[0], p[0], v[W-1:0]);
              verify();
            end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule